// File: doc/BRIEF.md
# Paged Address Translator with Protection Faults

This block widens a 16-bit logical address from an 8-bit processor into a 20-bit physical memory address. The upper four logical address bits select one of sixteen mapping entries, and each entry supplies an 8-bit physical page number that is joined to the 12-bit offset within the 4 KB page. Each entry also carries three flags: valid, write-protect and no-execute. An input strobe marks opcode fetch cycles, so the block can tell an instruction fetch apart from a data read.

In every access cycle the block checks the selected entry. Three conditions raise a fault: any access to an invalid entry, a write to a write-protected entry, and an opcode fetch from a no-execute entry. A faulting access never reaches memory. The block captures the cause and the logical address in a status register and holds the processor's ready line low until the status is cleared. A configuration port reads and writes the mapping entries and the control registers. The processor can drive this port, and so can another bus master while the processor is stalled and disconnected. The same port also returns the processor's current address.

Top module: `pgmmu_top`

## Requirements
- R1: With `cpu_valid` high and no fault, `mem_req` is high and `mem_addr` equals {entry page number, `cpu_addr[11:0]`}. The entry is indexed by `cpu_addr[15:12]`.
- R2: After reset, entry i holds page number i with the valid flag set and the write-protect and no-execute flags clear, so reads of entry i return 0x0100+i. An asynchronous reset restores this state at any time.
- R3: A write (`cpu_we`=1) to a valid write-protected entry drops `mem_req` and `cpu_ready` and records cause 3'b010. Reads from that page still proceed.
- R4: Any access to an entry whose valid flag is clear drops `mem_req` and `cpu_ready` and records cause 3'b001.
- R5: An opcode fetch (`cpu_fetch`=1) from a valid no-execute entry faults with cause 3'b100. A data read from the same page proceeds normally.
- R6: On a fault, the next clock edge captures the status (read at control index 0 as bit 3 = pending, bits 2:0 = cause) and the logical address (control index 1). Both hold, and `cpu_ready` stays low, until a clear. Later faults do not overwrite them.
- R7: A configuration write to control index 0 clears the pending flag, the cause and the fault address. `cpu_ready` returns high in the next cycle.
- R8: Entry layout is bits 7:0 page number, bit 8 valid, bit 9 write-protect, bit 10 no-execute. A configuration write with `cfg_map`=1 stores into entry `cfg_rs`, and a read returns it. Control index 2 returns the current `cpu_addr`.
- R9: When several fault conditions hold, only one cause bit is recorded, with the priority invalid > write-protect > no-execute.
- R10: `mem_we` is high only when `cpu_we` is high and `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Logical address from the processor |
| cpu_valid | input | 1 | Processor access cycle in progress |
| cpu_we | input | 1 | Access is a write |
| cpu_fetch | input | 1 | Access is an opcode fetch |
| cpu_ready | output | 1 | Ready to the processor, low while a fault is seen or pending |
| mem_addr | output | 20 | Physical address |
| mem_req | output | 1 | Memory access enable, suppressed on fault |
| mem_we | output | 1 | Memory write enable |
| cfg_en | input | 1 | Configuration port select |
| cfg_map | input | 1 | 1 selects mapping entries, 0 selects control registers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rs | input | 4 | Register select |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data, zero when not selected |

## Verification
The assertions check the following on every cycle:
- a captured status stays frozen while no clear arrives, and a clear empties it;
- the recorded cause never has more than one bit set;
- memory is never requested for an invalid or write-protected write target;
- the page offset passes through unchanged;
- a mapping write is stored exactly.

Some behaviours show only in the bench's scenarios: the translated page values, the fault priority among combined flags, data reads from no-execute pages, a second fault being ignored, and the restoration of identity mapping after reset.

// File: rtl/pgmmu_pkg.sv
package pgmmu_pkg;
  localparam int CAUSE_W = 3;
  // cause bit positions
  localparam int C_UNMAP = 0;
  localparam int C_WPROT = 1;
  localparam int C_NOEXE = 2;
  // control register indices
  localparam int CTL_STATUS = 0;
  localparam int CTL_FADDR  = 1;
  localparam int CTL_CURADR = 2;
  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/pgmmu_maptab.sv
module pgmmu_maptab #(
  parameter int IDX_W = 4,
  parameter int PPN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       lk_idx,
  output logic [PPN_W-1:0]       lk_ppn,
  output logic                   lk_vld,
  output logic                   lk_wp,
  output logic                   lk_nx,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [PPN_W+2:0]       wr_data,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [PPN_W+2:0]       rd_data
);
  localparam int NENT = 1 << IDX_W;
  localparam int EW   = PPN_W + 3;

  logic [EW-1:0] ent_q [NENT];
  logic [EW-1:0] ent_d [NENT];

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    always_comb begin
      ent_d[i] = ent_q[i];
      if (wr_en && (wr_idx == IDX_W'(i))) ent_d[i] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[i] <= {3'b001, PPN_W'(i)};
      else        ent_q[i] <= ent_d[i];
    end
  end

  logic [EW-1:0] lk_e;
  always_comb begin
    lk_e    = ent_q[lk_idx];
    lk_ppn  = lk_e[PPN_W-1:0];
    lk_vld  = lk_e[PPN_W];
    lk_wp   = lk_e[PPN_W+1];
    lk_nx   = lk_e[PPN_W+2];
    rd_data = ent_q[rd_idx];
  end

  // R8: a mapping write lands unchanged in the addressed entry
  assert_map_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/pgmmu_xlate.sv
module pgmmu_xlate
  import pgmmu_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PPN_W = 8
) (
  input  logic [OFF_W-1:0]       offset,
  input  logic [PPN_W-1:0]       ppn,
  input  logic                   vld,
  input  logic                   wp,
  input  logic                   nx,
  input  logic                   acc,
  input  logic                   wr,
  input  logic                   fetch,
  output logic [PPN_W+OFF_W-1:0] phys,
  output logic                   fault,
  output cause_t                 cause
);
  always_comb begin
    phys  = {ppn, offset};
    cause = '0;
    if (acc) begin
      if (!vld)              cause[C_UNMAP] = 1'b1;
      else if (wr && wp)     cause[C_WPROT] = 1'b1;
      else if (fetch && nx)  cause[C_NOEXE] = 1'b1;
    end
    fault = |cause;
  end
endmodule

// File: rtl/pgmmu_faultreg.sv
module pgmmu_faultreg
  import pgmmu_pkg::*;
#(
  parameter int LA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_now,
  input  cause_t          cause_now,
  input  logic [LA_W-1:0] cpu_addr,
  input  logic            clr,
  output logic            pend_q,
  output cause_t          cause_q,
  output logic [LA_W-1:0] faddr_q
);
  logic            pend_d;
  cause_t          cause_d;
  logic [LA_W-1:0] faddr_d;
  logic            cap, upd_en;

  always_comb begin
    cap     = fault_now && !pend_q;
    upd_en  = cap || clr;
    pend_d  = 1'b0;
    cause_d = '0;
    faddr_d = '0;
    if (cap) begin
      pend_d  = 1'b1;
      cause_d = cause_now;
      faddr_d = cpu_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      cause_q <= '0;
      faddr_q <= '0;
    end else if (upd_en) begin
      pend_q  <= pend_d;
      cause_q <= cause_d;
      faddr_q <= faddr_d;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !clr |=> pend_q && $stable(cause_q) && $stable(faddr_q));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && clr |=> !pend_q && (cause_q == '0));
  assert_one_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause_q));
endmodule

// File: rtl/pgmmu_top.sv
module pgmmu_top
  import pgmmu_pkg::*;
#(
  parameter int LA_W  = 16,
  parameter int PA_W  = 20,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LA_W-1:0]  cpu_addr,
  input  logic             cpu_valid,
  input  logic             cpu_we,
  input  logic             cpu_fetch,
  output logic             cpu_ready,
  output logic [PA_W-1:0]  mem_addr,
  output logic             mem_req,
  output logic             mem_we,
  input  logic             cfg_en,
  input  logic             cfg_map,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_rs,
  input  logic [LA_W-1:0]  cfg_wdata,
  output logic [LA_W-1:0]  cfg_rdata
);
  localparam int OFF_W = LA_W - IDX_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int EW    = PPN_W + 3;

  logic [PPN_W-1:0] lk_ppn;
  logic             lk_vld, lk_wp, lk_nx;
  logic [EW-1:0]    ent_rd;
  logic             fault_now, pend_q;
  cause_t           cause_now, cause_q;
  logic [LA_W-1:0]  faddr_q;
  logic             map_wr, clr;
  logic             unused_wdata;

  assign unused_wdata = ^cfg_wdata[LA_W-1:EW];

  always_comb begin
    map_wr = cfg_en && cfg_we && cfg_map;
    clr    = cfg_en && cfg_we && !cfg_map && (cfg_rs == IDX_W'(CTL_STATUS));
  end

  pgmmu_maptab #(.IDX_W(IDX_W), .PPN_W(PPN_W)) maptab_i (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(cpu_addr[LA_W-1:OFF_W]),
    .lk_ppn(lk_ppn), .lk_vld(lk_vld), .lk_wp(lk_wp), .lk_nx(lk_nx),
    .wr_en(map_wr), .wr_idx(cfg_rs), .wr_data(cfg_wdata[EW-1:0]),
    .rd_idx(cfg_rs), .rd_data(ent_rd)
  );

  pgmmu_xlate #(.OFF_W(OFF_W), .PPN_W(PPN_W)) xlate_i (
    .offset(cpu_addr[OFF_W-1:0]), .ppn(lk_ppn),
    .vld(lk_vld), .wp(lk_wp), .nx(lk_nx),
    .acc(cpu_valid), .wr(cpu_we), .fetch(cpu_fetch),
    .phys(mem_addr), .fault(fault_now), .cause(cause_now)
  );

  pgmmu_faultreg #(.LA_W(LA_W)) fault_i (
    .clk(clk), .rst_n(rst_n),
    .fault_now(fault_now), .cause_now(cause_now),
    .cpu_addr(cpu_addr), .clr(clr),
    .pend_q(pend_q), .cause_q(cause_q), .faddr_q(faddr_q)
  );

  always_comb begin
    mem_req   = cpu_valid && !fault_now && !pend_q;
    mem_we    = mem_req && cpu_we;
    cpu_ready = !fault_now && !pend_q;
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_en) begin
      if (cfg_map) cfg_rdata = LA_W'(ent_rd);
      else begin
        case (cfg_rs)
          IDX_W'(CTL_STATUS): cfg_rdata = LA_W'({pend_q, cause_q});
          IDX_W'(CTL_FADDR):  cfg_rdata = faddr_q;
          IDX_W'(CTL_CURADR): cfg_rdata = cpu_addr;
          default:            cfg_rdata = '0;
        endcase
      end
    end
  end

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);
  assert_wp_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_we && lk_wp |-> !mem_we);
  assert_unmapped_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !lk_vld |-> !mem_req && !cpu_ready);
  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !cpu_ready && !mem_req);
  assert_we_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req && cpu_we);
endmodule

// File: tb/pgmmu_top_tb_top.sv
module pgmmu_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // {tag[45:42], addr[41:26], we[25], fetch[24], req[23], maddr[22:3], cause[2:0]}
  localparam logic [45:0] VEC [NV] = '{
    {4'd1, 16'h3ABC, 1'b0, 1'b0, 1'b1, 20'hA7ABC, 3'b000},  // R1 remapped read
    {4'd1, 16'h3001, 1'b1, 1'b0, 1'b1, 20'hA7001, 3'b000},  // R1 remapped write
    {4'd3, 16'h4010, 1'b0, 1'b0, 1'b1, 20'h04010, 3'b000},  // R3 read of protected page
    {4'd3, 16'h4010, 1'b1, 1'b0, 1'b0, 20'h00000, 3'b010},  // R3 protected write
    {4'd4, 16'h5FFF, 1'b0, 1'b0, 1'b0, 20'h00000, 3'b001},  // R4 invalid read
    {4'd4, 16'h5000, 1'b1, 1'b0, 1'b0, 20'h00000, 3'b001},  // R4 invalid write
    {4'd5, 16'h6123, 1'b0, 1'b0, 1'b1, 20'h66123, 3'b000},  // R5 data read allowed
    {4'd5, 16'h6124, 1'b0, 1'b1, 1'b0, 20'h00000, 3'b100},  // R5 fetch blocked
    {4'd9, 16'h7000, 1'b1, 1'b1, 1'b0, 20'h00000, 3'b001},  // R9 invalid wins
    {4'd9, 16'h8000, 1'b1, 1'b1, 1'b0, 20'h00000, 3'b010},  // R9 protect beats no-exec
    {4'd9, 16'h8000, 1'b0, 1'b1, 1'b0, 20'h00000, 3'b100},  // R9 fetch read -> no-exec
    {4'd2, 16'hF00F, 1'b0, 1'b1, 1'b1, 20'h0F00F, 3'b000}   // R2 untouched identity
  };

  logic        clk, rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_valid, cpu_we, cpu_fetch, cpu_ready;
  logic [19:0] mem_addr;
  logic        mem_req, mem_we;
  logic        cfg_en, cfg_map, cfg_we;
  logic [3:0]  cfg_rs;
  logic [15:0] cfg_wdata, cfg_rdata;
  int          checks, errors;

  pgmmu_top dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_valid(cpu_valid),
    .cpu_we(cpu_we), .cpu_fetch(cpu_fetch), .cpu_ready(cpu_ready),
    .mem_addr(mem_addr), .mem_req(mem_req), .mem_we(mem_we),
    .cfg_en(cfg_en), .cfg_map(cfg_map), .cfg_we(cfg_we), .cfg_rs(cfg_rs),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic map, input logic [3:0] rs, input logic [15:0] d);
    @(negedge clk);
    cfg_en = 1'b1; cfg_map = map; cfg_we = 1'b1; cfg_rs = rs; cfg_wdata = d;
    @(negedge clk);
    cfg_en = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic map, input logic [3:0] rs, output logic [15:0] d);
    cfg_en = 1'b1; cfg_map = map; cfg_we = 1'b0; cfg_rs = rs;
    #1 d = cfg_rdata;
    cfg_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    checks = 0; errors = 0;
    rst_n = 1'b0; cpu_addr = '0; cpu_valid = 0; cpu_we = 0; cpu_fetch = 0;
    cfg_en = 0; cfg_map = 0; cfg_we = 0; cfg_rs = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R2 ready after reset", 32'(cpu_ready), 32'd1);
    cfg_rd(1'b0, 4'd0, rd); chk("R6 status after reset", 32'(rd), 32'h0);
    cfg_rd(1'b1, 4'd9, rd); chk("R2 entry 9 after reset", 32'(rd), 32'h0109);
    cpu_addr = 16'h5123; cpu_valid = 1'b1; #1;
    chk("R2 identity addr", 32'(mem_addr), 32'h05123);
    chk("R2 identity req", 32'(mem_req), 32'd1);
    cpu_valid = 1'b0;

    cfg_wr(1'b1, 4'd3, 16'h01A7);
    cfg_wr(1'b1, 4'd4, 16'h0304);
    cfg_wr(1'b1, 4'd5, 16'h0000);
    cfg_wr(1'b1, 4'd6, 16'h0566);
    cfg_wr(1'b1, 4'd7, 16'h0677);
    cfg_wr(1'b1, 4'd8, 16'h0708);
    #1;
    cfg_rd(1'b1, 4'd3, rd); chk("R8 entry 3 readback", 32'(rd), 32'h01A7);
    cfg_rd(1'b1, 4'd6, rd); chk("R8 entry 6 readback", 32'(rd), 32'h0566);

    for (int k = 0; k < NV; k++) begin
      logic [45:0] v;
      string tg;
      v = VEC[k];
      tg = $sformatf("R%0d vec%0d", v[45:42], k);
      @(negedge clk);
      cpu_addr = v[41:26]; cpu_we = v[25]; cpu_fetch = v[24]; cpu_valid = 1'b1;
      #1;
      chk({tg, " mem_req"}, 32'(mem_req), 32'(v[23]));
      chk({tg, " ready"}, 32'(cpu_ready), 32'(v[23]));
      chk({"R10 ", tg, " mem_we"}, 32'(mem_we), 32'(v[23] & v[25]));
      if (v[23]) chk({tg, " mem_addr"}, 32'(mem_addr), 32'(v[22:3]));
      @(negedge clk); #1;
      if (!v[23]) begin
        chk({"R6 ", tg, " ready held low"}, 32'(cpu_ready), 32'd0);
        cfg_rd(1'b0, 4'd0, rd);
        chk({"R6 ", tg, " status"}, 32'(rd), 32'({1'b1, v[2:0]}));
        cfg_rd(1'b0, 4'd1, rd);
        chk({"R6 ", tg, " fault addr"}, 32'(rd), 32'(v[41:26]));
        cpu_valid = 1'b0;
        cfg_wr(1'b0, 4'd0, 16'h0);
        #1;
        chk({"R7 ", tg, " ready after clear"}, 32'(cpu_ready), 32'd1);
        cfg_rd(1'b0, 4'd0, rd);
        chk({"R7 ", tg, " status after clear"}, 32'(rd), 32'h0);
      end
      cpu_valid = 1'b0; cpu_we = 1'b0; cpu_fetch = 1'b0;
    end

    // R6: a second fault while pending leaves status untouched
    @(negedge clk);
    cpu_addr = 16'h5000; cpu_valid = 1'b1;
    @(negedge clk);
    cpu_addr = 16'h4ABC; cpu_we = 1'b1;
    @(negedge clk); #1;
    cfg_rd(1'b0, 4'd0, rd); chk("R6 status kept", 32'(rd), 32'h9);
    cfg_rd(1'b0, 4'd1, rd); chk("R6 fault addr kept", 32'(rd), 32'h5000);
    chk("R6 no mem_req while pending", 32'(mem_req), 32'd0);
    cpu_valid = 1'b0; cpu_we = 1'b0;
    cfg_wr(1'b0, 4'd0, 16'h0);
    #1 chk("R7 ready after second clear", 32'(cpu_ready), 32'd1);

    // R8: current processor address port
    cpu_addr = 16'hBEEF;
    cfg_rd(1'b0, 4'd2, rd); chk("R8 current address", 32'(rd), 32'hBEEF);

    // R2: asynchronous reset restores identity mapping
    @(negedge clk);
    rst_n = 1'b0; #1;
    cfg_rd(1'b1, 4'd3, rd); chk("R2 entry 3 after reset", 32'(rd), 32'h0103);
    cfg_rd(1'b1, 4'd5, rd); chk("R2 entry 5 after reset", 32'(rd), 32'h0105);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cpu_addr = 16'h3456; cpu_valid = 1'b1; #1;
    chk("R2 identity after reset", 32'(mem_addr), 32'h03456);
    cpu_valid = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule